// File: doc/BRIEF.md
# Indirect Wait-State Control Unit

This block stretches the bus cycles of a small 8-bit processor. Software configures it through two I/O locations. One location holds a pointer. The other reads or writes whichever of four control registers that pointer selects. When the processor starts a bus cycle, it pulses a start strobe and gives the cycle's kind. The block then raises its wait output for a number of clocks that it composes from fields of the wait control register.

Each kind of cycle has its own wait count:

- Memory accesses and I/O accesses each take their count from a separate two-bit field.
- Opcode fetches take the memory count plus an optional one-clock penalty.
- Interrupt-vector reads take an optional single wait.
- Interrupt acknowledge and return-from-interrupt cycles take their counts from a shared chain-delay code.

The two boundary registers and the miscellaneous register are only stored and read back. The miscellaneous fields are also brought out as plain control levels for neighbouring logic.

Top module: `cyc_wait_ctrl`

## Requirements
- R1: After a synchronous reset, the pointer and all four control registers read 0x00, and `wait_out` is low.
- R2: A write to I/O address 0xEE loads the pointer with the data byte. A read of 0xEE returns the pointer. Read data appears on `io_rdata` in the clock after the read strobe, and `io_rdata` is 0x00 when no read hits either address.
- R3: A write to 0xEF stores the byte in the register the pointer selects, and a read of 0xEF returns it. Pointer 0 selects wait control, 1 selects the memory boundary, 2 selects the chip-select boundary and 3 selects the miscellaneous register.
- R4: While the pointer is above 3, a read of 0xEF returns 0xFF and a write to 0xEF changes no register.
- R5: An I/O cycle (`cyc_type` 1) waits twice the value of wait-control bits [1:0], giving 0, 2, 4 or 6 clocks.
- R6: A memory cycle (`cyc_type` 0) waits the value of wait-control bits [3:2], giving 0 to 3 clocks.
- R7: An opcode fetch (`cyc_type` 2) waits the memory count plus wait-control bit 4.
- R8: An interrupt-vector read (`cyc_type` 3) waits wait-control bit 5.
- R9: Wait-control bits [7:6] form a chain code c. An acknowledge (`cyc_type` 4) waits 2·c. A return-from-interrupt (`cyc_type` 5) waits 0 when c is 0 and 2·(c−1) otherwise. Types 6 and 7 wait 0.
- R10: After a start strobe with count N, `wait_out` is high for exactly the N clocks that follow the start edge and is then low. When N is 0, `wait_out` stays low.
- R11: Miscellaneous register bit 0 drives `cs0_en` and bit 1 drives `cs1_en`. Bit 4 drives `clk_div1` (set means divide by one). `reset_out_en` is the inverse of bit 3.
- R12: A start strobe during an active wait discards the remaining count and reloads the counter with the new cycle's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O address of the current access |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_type | input | 3 | Cycle kind: 0 memory, 1 I/O, 2 opcode fetch, 3 vector read, 4 acknowledge, 5 return-from-interrupt |
| wait_out | output | 1 | Wait request, high while waits remain |
| mem_bound | output | 8 | Stored memory wait boundary |
| cs_bound | output | 8 | Stored chip-select boundary |
| cs0_en | output | 1 | Chip-select 0 enable |
| cs1_en | output | 1 | Chip-select 1 enable |
| reset_out_en | output | 1 | Reset output enable (active when misc bit 3 is clear) |
| clk_div1 | output | 1 | Clock divide-by-one select |

## Verification
The bench programs random wait-control bytes and fires every cycle kind. Each wait pulse is measured in clocks against a model of the field arithmetic. A design that mixed up the field positions or missed the opcode-fetch addition would miscount there. The chain codes are swept directly, because a return-from-interrupt table shifted by one entry would give nonzero waits at code 1. Pointer values above 3 are exercised both for the 0xFF read and for write suppression, which exposes a pointer truncated to two bits that aliases onto a real register. A restart during a long I/O wait catches a counter that ignores a new strobe or adds the two counts together.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [2:0] {
    CYC_MEM   = 3'd0,
    CYC_IO    = 3'd1,
    CYC_FETCH = 3'd2,
    CYC_VEC   = 3'd3,
    CYC_ACK   = 3'd4,
    CYC_RETI  = 3'd5,
    CYC_NONE6 = 3'd6,
    CYC_NONE7 = 3'd7
  } cyc_kind_t;

  localparam int REG_WAIT   = 0;
  localparam int REG_MBOUND = 1;
  localparam int REG_CBOUND = 2;
  localparam int REG_MISC   = 3;
endpackage

// File: rtl/cwc_regfile.sv
module cwc_regfile #(
  parameter int DW = 8,
  parameter int NREG = 4,
  parameter logic [7:0] PTR_ADDR = 8'hEE,
  parameter logic [7:0] DATA_ADDR = 8'hEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic [DW-1:0] reg_wait,
  output logic [DW-1:0] reg_mbound,
  output logic [DW-1:0] reg_cbound,
  output logic [DW-1:0] reg_misc
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] ptr_q;
  logic [DW-1:0] regs_q [NREG];
  logic          ptr_ok;
  logic [IDX_W-1:0] sel;
  logic          hit_ptr, hit_data;

  assign ptr_ok   = (ptr_q < DW'(NREG));
  assign sel      = ptr_q[IDX_W-1:0];
  assign hit_ptr  = (io_addr == PTR_ADDR);
  assign hit_data = (io_addr == DATA_ADDR);

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (io_wr && hit_ptr) ptr_q <= io_wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (io_wr && hit_data && ptr_ok && (sel == IDX_W'(g)))
        regs_q[g] <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_rd && hit_ptr) io_rdata <= ptr_q;
    else if (io_rd && hit_data) io_rdata <= ptr_ok ? regs_q[sel] : '1;
    else io_rdata <= '0;
  end

  assign reg_wait   = regs_q[cwc_pkg::REG_WAIT];
  assign reg_mbound = regs_q[cwc_pkg::REG_MBOUND];
  assign reg_cbound = regs_q[cwc_pkg::REG_CBOUND];
  assign reg_misc   = regs_q[cwc_pkg::REG_MISC];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ptr_q == '0 && reg_wait == '0 && reg_misc == '0));

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && hit_ptr) |=> (ptr_q == $past(io_wdata)));

  // R3
  data_store_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && hit_data && ptr_ok) |=> (regs_q[$past(sel)] == $past(io_wdata)));

  // R4
  bad_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && hit_data && !ptr_ok) |=>
      ($stable(reg_wait) && $stable(reg_mbound) && $stable(reg_cbound) && $stable(reg_misc)));
endmodule

// File: rtl/cwc_wait_calc.sv
module cwc_wait_calc #(
  parameter int DW = 8,
  parameter int CNT_W = 3
) (
  input  logic [DW-1:0]    wcr,
  input  logic [2:0]       cyc_type,
  output logic [CNT_W-1:0] n_waits
);
  import cwc_pkg::*;

  logic [3:0] io_n, mem_n, fetch_n, vec_n, ack_n, reti_n, sel_n;
  logic [1:0] chain;

  assign chain   = wcr[7:6];
  assign io_n    = {1'b0, wcr[1:0], 1'b0};
  assign mem_n   = {2'b00, wcr[3:2]};
  assign fetch_n = mem_n + {3'b000, wcr[4]};
  assign vec_n   = {3'b000, wcr[5]};
  assign ack_n   = {1'b0, chain, 1'b0};
  assign reti_n  = (chain == 2'd0) ? 4'd0 : {1'b0, chain - 2'd1, 1'b0};

  always_comb begin
    unique case (cyc_kind_t'(cyc_type))
      CYC_MEM:   sel_n = mem_n;
      CYC_IO:    sel_n = io_n;
      CYC_FETCH: sel_n = fetch_n;
      CYC_VEC:   sel_n = vec_n;
      CYC_ACK:   sel_n = ack_n;
      CYC_RETI:  sel_n = reti_n;
      default:   sel_n = 4'd0;
    endcase
  end

  assign n_waits = CNT_W'(sel_n);
endmodule

// File: rtl/cwc_wait_timer.sv
module cwc_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] n_in,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= n_in;
      busy  <= (n_in != '0);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      busy  <= (cnt_q > CNT_W'(1));
    end
  end

  // R12
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(n_in)));

  // R10
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && cnt_q == '0) |=> !busy);
endmodule

// File: rtl/cyc_wait_ctrl.sv
module cyc_wait_ctrl #(
  parameter int DW = 8,
  parameter int NREG = 4,
  parameter int CNT_W = 3,
  parameter logic [7:0] PTR_ADDR = 8'hEE,
  parameter logic [7:0] DATA_ADDR = 8'hEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic          cyc_start,
  input  logic [2:0]    cyc_type,
  output logic          wait_out,
  output logic [DW-1:0] mem_bound,
  output logic [DW-1:0] cs_bound,
  output logic          cs0_en,
  output logic          cs1_en,
  output logic          reset_out_en,
  output logic          clk_div1
);
  logic [DW-1:0]    reg_wait, reg_misc;
  logic [CNT_W-1:0] n_waits;

  cwc_regfile #(.DW(DW), .NREG(NREG), .PTR_ADDR(PTR_ADDR), .DATA_ADDR(DATA_ADDR)) u_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .reg_wait(reg_wait),
    .reg_mbound(mem_bound), .reg_cbound(cs_bound), .reg_misc(reg_misc)
  );

  cwc_wait_calc #(.DW(DW), .CNT_W(CNT_W)) u_calc (
    .wcr(reg_wait), .cyc_type(cyc_type), .n_waits(n_waits)
  );

  cwc_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start(cyc_start), .n_in(n_waits), .busy(wait_out)
  );

  assign cs0_en       = reg_misc[0];
  assign cs1_en       = reg_misc[1];
  assign reset_out_en = ~reg_misc[3];
  assign clk_div1     = reg_misc[4];

  // R11
  misc_reset_level_chk: assert property (@(posedge clk)
    rst |=> (reset_out_en && !clk_div1 && !cs0_en && !cs1_en));
endmodule

// File: tb/cyc_wait_ctrl_tb.sv
`timescale 1ns/1ps
module cyc_wait_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic io_wr = 1'b0, io_rd = 1'b0, cyc_start = 1'b0;
  logic [2:0] cyc_type = '0;
  logic wait_out, cs0_en, cs1_en, reset_out_en, clk_div1;
  logic [7:0] mem_bound, cs_bound;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cyc_wait_ctrl u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cyc_start(cyc_start),
    .cyc_type(cyc_type), .wait_out(wait_out), .mem_bound(mem_bound),
    .cs_bound(cs_bound), .cs0_en(cs0_en), .cs1_en(cs1_en),
    .reset_out_en(reset_out_en), .clk_div1(clk_div1)
  );

  function automatic int exp_waits(logic [7:0] w, int t);
    int c = int'(w[7:6]);
    case (t)
      0: return int'(w[3:2]);
      1: return 2 * int'(w[1:0]);
      2: return int'(w[3:2]) + int'(w[4]);
      3: return int'(w[5]);
      4: return 2 * c;
      5: return (c == 0) ? 0 : 2 * (c - 1);
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = io_rdata;
  endtask

  task automatic run_cycle(int t, output int n);
    @(negedge clk); cyc_type = 3'(t); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    n = 0;
    while (wait_out && n < 20) begin n++; @(negedge clk); end
  endtask

  task automatic set_wcr(logic [7:0] w);
    io_write(8'hEE, 8'h00);
    io_write(8'hEF, w);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 wait_out", int'(wait_out), 0);
    io_read(8'hEE, d); check("R1 pointer", int'(d), 0);
    for (int i = 0; i < 4; i++) begin
      io_write(8'hEE, 8'(i)); io_read(8'hEF, d); check("R1 reg", int'(d), 0);
    end
    // R2 pointer and idle read data
    io_write(8'hEE, 8'h02); io_read(8'hEE, d); check("R2 ptr readback", int'(d), 2);
    io_read(8'h10, d); check("R2 miss read zero", int'(d), 0);
    // R3 each register
    for (int i = 0; i < 4; i++) begin
      io_write(8'hEE, 8'(i)); io_write(8'hEF, 8'(8'h5A + i));
    end
    for (int i = 0; i < 4; i++) begin
      io_write(8'hEE, 8'(i)); io_read(8'hEF, d); check("R3 reg readback", int'(d), 8'h5A + i);
    end
    check("R3 mem_bound", int'(mem_bound), 8'h5B);
    check("R3 cs_bound", int'(cs_bound), 8'h5C);
    // R4 pointer above 3
    io_write(8'hEE, 8'h04); io_read(8'hEF, d); check("R4 read FF", int'(d), 8'hFF);
    io_write(8'hEF, 8'h99);
    io_write(8'hEE, 8'hF8); io_write(8'hEF, 8'h77);
    for (int i = 0; i < 4; i++) begin
      io_write(8'hEE, 8'(i)); io_read(8'hEF, d); check("R4 no write", int'(d), 8'h5A + i);
    end
    // R11 misc decode
    io_write(8'hEE, 8'h03); io_write(8'hEF, 8'h19);
    check("R11 cs0_en", int'(cs0_en), 1);
    check("R11 cs1_en", int'(cs1_en), 0);
    check("R11 reset_out_en", int'(reset_out_en), 0);
    check("R11 clk_div1", int'(clk_div1), 1);
    io_write(8'hEF, 8'h02);
    check("R11 cs1_en set", int'(cs1_en), 1);
    check("R11 reset_out_en on", int'(reset_out_en), 1);
    check("R11 clk_div1 clr", int'(clk_div1), 0);
    // R9 chain sweep
    for (int c = 0; c < 4; c++) begin
      set_wcr(8'(c << 6));
      run_cycle(4, n); check("R9 ack", n, 2 * c);
      run_cycle(5, n); check("R9 reti", n, (c == 0) ? 0 : 2 * (c - 1));
    end
    // R5 R6 R7 R8 R10 directed corners
    set_wcr(8'h3F);
    run_cycle(1, n); check("R5 io max", n, 6);
    run_cycle(0, n); check("R6 mem max", n, 3);
    run_cycle(2, n); check("R7 fetch max", n, 4);
    run_cycle(3, n); check("R8 vec", n, 1);
    set_wcr(8'h00);
    run_cycle(2, n); check("R10 zero waits", n, 0);
    // R12 restart during active wait
    set_wcr(8'h23);
    @(negedge clk); cyc_type = 3'd1; cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 still busy", int'(wait_out), 1);
    cyc_type = 3'd3; cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
    n = 0;
    while (wait_out && n < 20) begin n++; @(negedge clk); end
    check("R12 reload count", n, 1);
    // random mix R5..R9
    for (int k = 0; k < 60; k++) begin
      logic [7:0] w = 8'($urandom);
      int t = int'($urandom_range(0, 7));
      set_wcr(w);
      run_cycle(t, n);
      check("R5-R9 random (R10)", n, exp_waits(w, t));
    end
    // R1 reset again clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    io_read(8'hEE, d); check("R1 re-reset ptr", int'(d), 0);
    io_read(8'hEF, d); check("R1 re-reset wcr", int'(d), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule